// File: doc/BRIEF.md
# Synchronous Serial Receive Unit

This block is the receive half of a clocked serial port that works either as the clock master or as a slave. As master it produces the transfer clock itself. As slave it takes bits from an external transfer clock, but only while an active-low select input is held low. Each frame is collected into a shift register. When the frame is complete it is copied into a receive data register and a full flag is raised. An interrupt request can follow that flag.

Software drives the unit through a small register port. Reception is armed by setting the enable bit and then reading the data register once; that read is a dummy read. Each later read clears the full flag.

The unit also handles a frame that begins while unread data is still held. If the held data is read before that frame ends, a sticky conflict flag is raised. If it is not read, the new frame is dropped and no flag is raised. In master mode, every read of the data register while enabled clocks exactly one frame.

Top module: `sync_rx_core`

## Requirements
- R1: No bit is accepted after reset or after enabling until the data register (address 2) has been read while the enable bit (control register, address 0, bit 0) is 1.
- R2: In slave mode, one bit is shifted in on each rising edge of `ext_sclk` while `ext_sel_n` is low. The first bit becomes the most significant bit of an 8-bit frame.
- R3: At the end of a frame that began with the full flag clear, the frame is copied into the data register and the full flag (status register, address 1, bit 0) becomes 1.
- R4: `rx_irq` is high exactly when the full flag is 1 and the interrupt enable (control bit 1) is 1.
- R5: A read of the data register clears the full flag, unless a frame completes in the same cycle.
- R6: If a frame begins while the full flag is 1, and the data register is read before that frame ends, the conflict flag (status bit 1) becomes 1 at the frame end. The new frame is dropped.
- R7: If a frame begins while the full flag is 1, and no read occurs before that frame ends, the frame is dropped. The full flag stays 1, the held data is unchanged and the conflict flag stays 0.
- R8: The conflict flag is sticky. Writing the status register with bit 1 = 0 clears it; writing it with bit 1 = 1 leaves it unchanged.
- R9: Clearing the enable bit discards a partial frame and disarms reception. After re-enabling, a new dummy read is needed.
- R10: In master mode (control bit 2), each read of the data register while enabled and idle produces exactly 8 high pulses on `mst_sclk`. Each half period lasts HALF_DIV system clocks, the idle level is low, and `ser_din` is sampled as the clock rises, MSB first.
- R11: In slave mode, raising `ext_sel_n` part-way through a frame discards the partial frame, so the next selected frame is received aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| ext_sclk | input | 1 | Transfer clock from an external master (slave mode) |
| ext_sel_n | input | 1 | Active-low select from an external master (slave mode) |
| ser_din | input | 1 | Serial data input |
| mst_sclk | output | 1 | Transfer clock driven in master mode |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench's main target is a frame that starts while stale data is held.

- **Read part-way through that frame.** The bench checks that the conflict flag rises and the stale byte survives. A design that let the late frame overwrite the register, or that never set the flag, would return the new byte or a clear status.
- **No read during that frame.** The bench checks that the full flag stays set and that no error appears. A design that treated this as an overrun, or stored the data, would be caught.
- **Arming and aborts.** Frames are sent before the dummy read, after the enable bit is toggled mid-frame, and after the select is dropped mid-frame. A design with a stale bit counter would return a shifted byte.
- **Master mode.** The bench counts clock pulses per read. A generator that ran on, or stopped one edge short, shows the wrong count or wrong data.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_STAT = 2'd1,
        ADDR_DATA = 2'd2
    } reg_addr_e;

    // control register fields
    localparam int CTRL_EN  = 0;
    localparam int CTRL_IRQ = 1;
    localparam int CTRL_MST = 2;

    // status register fields
    localparam int STAT_FULL = 0;
    localparam int STAT_ERR  = 1;

    // bit positions in the synchroniser vector
    localparam int SY_SCLK = 0;
    localparam int SY_SEL  = 1;
    localparam int SY_DIN  = 2;
    localparam int SY_W    = 3;
endpackage

// File: rtl/sync_rx_sync.sv
module sync_rx_sync #(
    parameter int               W       = 3,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d          = sy_q;
        sy_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            sy_d.chain[i] = sy_q.chain[i-1];
        end
        sy_d.prev = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q.chain <= {STAGES{RST_VAL}};
            sy_q.prev  <= RST_VAL;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign sync_o = sy_q.chain[STAGES-1];
    assign rise_o = sy_q.chain[STAGES-1] & ~sy_q.prev;
endmodule

// File: rtl/sync_rx_mclk.sv
module sync_rx_mclk #(
    parameter int HALF_DIV   = 4,
    parameter int FRAME_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic abort_i,
    output logic sclk_o,
    output logic sample_o,
    output logic busy_o
);
    localparam int DIV_W    = $clog2(HALF_DIV + 1);
    localparam int TOG_N    = 2 * FRAME_BITS;
    localparam int TOG_W    = $clog2(TOG_N);

    typedef struct packed {
        logic             busy;
        logic             sclk;
        logic [DIV_W-1:0] div;
        logic [TOG_W-1:0] tog;
    } mc_t;

    mc_t  mc_d, mc_q;
    logic tick;

    always_comb begin
        mc_d     = mc_q;
        tick     = mc_q.busy && (mc_q.div == DIV_W'(HALF_DIV - 1));
        sample_o = tick && !mc_q.sclk;
        if (abort_i) begin
            mc_d = '0;
        end else if (!mc_q.busy) begin
            if (start_i) begin
                mc_d.busy = 1'b1;
                mc_d.div  = '0;
                mc_d.tog  = '0;
            end
        end else if (tick) begin
            mc_d.div  = '0;
            mc_d.sclk = !mc_q.sclk;
            mc_d.tog  = mc_q.tog + 1'b1;
            if (mc_q.tog == TOG_W'(TOG_N - 1)) begin
                mc_d.busy = 1'b0;
            end
        end else begin
            mc_d.div = mc_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mc_q <= '0;
        else        mc_q <= mc_d;
    end

    assign sclk_o = mc_q.sclk;
    assign busy_o = mc_q.busy;

    // R10: the master clock rests low whenever no frame is running
    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_q.busy |-> !mc_q.sclk);

    // R10: a start request while idle launches a frame on the next cycle
    assert_start_runs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !abort_i && !mc_q.busy) |=> mc_q.busy);
endmodule

// File: rtl/sync_rx_core.sv
module sync_rx_core
    import sync_rx_pkg::*;
#(
    parameter int FRAME_BITS  = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [FRAME_BITS-1:0] reg_wdata,
    output logic [FRAME_BITS-1:0] reg_rdata,
    input  logic                  ext_sclk,
    input  logic                  ext_sel_n,
    input  logic                  ser_din,
    output logic                  mst_sclk,
    output logic                  rx_irq
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  en;
        logic                  irq_en;
        logic                  mst;
        logic                  armed;
        logic                  full;
        logic                  err;
        logic                  late;
        logic                  rd_seen;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] shreg;
        logic [FRAME_BITS-1:0] data;
    } rx_t;

    rx_t  rx_d, rx_q;

    logic [SY_W-1:0]       sy_val, sy_rise;
    logic                  m_sample, m_busy, m_start, m_abort;
    logic                  rd_data, shift, last_bit, bit_in;
    logic [FRAME_BITS-1:0] shin;
    logic                  unused_bits;

    sync_rx_sync #(
        .W       (SY_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SY_W'(1) << SY_SEL)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_din, ext_sel_n, ext_sclk}),
        .sync_o  (sy_val),
        .rise_o  (sy_rise)
    );

    sync_rx_mclk #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS)
    ) u_mclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (m_start),
        .abort_i  (m_abort),
        .sclk_o   (mst_sclk),
        .sample_o (m_sample),
        .busy_o   (m_busy)
    );

    assign unused_bits = ^{sy_rise[SY_SEL], sy_rise[SY_DIN], reg_wdata};

    always_comb begin
        rx_d     = rx_q;
        rd_data  = reg_rd && (reg_addr == ADDR_DATA);
        last_bit = (rx_q.cnt == CNT_W'(FRAME_BITS - 1));
        shift    = rx_q.en && rx_q.armed &&
                   (rx_q.mst ? m_sample : (!sy_val[SY_SEL] && sy_rise[SY_SCLK]));
        bit_in   = rx_q.mst ? ser_din : sy_val[SY_DIN];
        shin     = {rx_q.shreg[FRAME_BITS-2:0], bit_in};
        m_start  = rd_data && rx_q.en && rx_q.mst && !m_busy;
        m_abort  = !rx_q.en || !rx_q.mst;

        // register port
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            rx_d.en     = reg_wdata[CTRL_EN];
            rx_d.irq_en = reg_wdata[CTRL_IRQ];
            rx_d.mst    = reg_wdata[CTRL_MST];
        end
        if (reg_wr && reg_addr == ADDR_STAT && !reg_wdata[STAT_ERR]) begin
            rx_d.err = 1'b0;
        end
        if (rd_data) begin
            rx_d.full = 1'b0;
            if (rx_q.en)        rx_d.armed   = 1'b1;
            if (rx_q.cnt != '0) rx_d.rd_seen = 1'b1;
        end

        // frame assembly
        if (!rx_q.en) begin
            rx_d.armed   = 1'b0;
            rx_d.cnt     = '0;
            rx_d.late    = 1'b0;
            rx_d.rd_seen = 1'b0;
        end else if (!rx_q.mst && sy_val[SY_SEL]) begin
            rx_d.cnt     = '0;
            rx_d.late    = 1'b0;
            rx_d.rd_seen = 1'b0;
        end else if (shift) begin
            rx_d.shreg = shin;
            if (rx_q.cnt == '0) begin
                rx_d.late    = rx_q.full && !rd_data;
                rx_d.rd_seen = 1'b0;
            end
            if (last_bit) begin
                rx_d.cnt     = '0;
                rx_d.late    = 1'b0;
                rx_d.rd_seen = 1'b0;
                if (!rx_q.late) begin
                    rx_d.data = shin;
                    rx_d.full = 1'b1;
                end else if (rx_q.rd_seen || rd_data) begin
                    rx_d.err = 1'b1;
                end
            end else begin
                rx_d.cnt = rx_q.cnt + 1'b1;
            end
        end

        // read mux
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[CTRL_EN]  = rx_q.en;
                reg_rdata[CTRL_IRQ] = rx_q.irq_en;
                reg_rdata[CTRL_MST] = rx_q.mst;
            end
            ADDR_STAT: begin
                reg_rdata[STAT_FULL] = rx_q.full;
                reg_rdata[STAT_ERR]  = rx_q.err;
            end
            ADDR_DATA: reg_rdata = rx_q.data;
            default:   reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_irq = rx_q.full && rx_q.irq_en;

    // R3: the full flag only rises on the cycle after a final bit is shifted
    assert_full_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_q.full) |-> $past(shift && last_bit));

    // R5: a data read with no frame completing leaves the flag clear
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !(shift && last_bit)) |=> !rx_q.full);

    // R6: the conflict flag rises only at the end of a late frame
    assert_err_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_q.err) |-> $past(shift && last_bit && rx_q.late));

    // R7: a late frame never overwrites held data
    assert_late_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && last_bit && rx_q.late) |=> $stable(rx_q.data));

    // R9: while disabled the bit counter is empty and reception disarmed
    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_q.en |=> (rx_q.cnt == '0 && !rx_q.armed));
endmodule

// File: tb/sync_rx_core_bench.sv
`timescale 1ns/1ps
module sync_rx_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_sclk = 1'b0, ext_sel_n = 1'b1, ser_din = 1'b0;
    logic       mst_sclk, rx_irq;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 1'b0;
    logic [7:0] v;

    always #2.5 clk = ~clk;

    sync_rx_core u_sync_rx_core (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ext_sclk(ext_sclk), .ext_sel_n(ext_sel_n), .ser_din(ser_din),
        .mst_sclk(mst_sclk), .rx_irq(rx_irq)
    );

    always @(posedge mst_sclk) edges++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clkn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic slave_bits(input logic [7:0] val, input int first, input int last);
        for (int i = first; i <= last; i++) begin
            ser_din = val[7-i];
            clkn(8); ext_sclk = 1'b1;
            clkn(8); ext_sclk = 1'b0;
        end
    endtask

    task automatic slave_frame(input logic [7:0] val);
        ext_sel_n = 1'b0; clkn(4);
        slave_bits(val, 0, 7);
        clkn(4); ext_sel_n = 1'b1; clkn(8);
    endtask

    task automatic master_drive(input logic [7:0] val);
        for (int i = 6; i >= 0; i--) begin
            @(negedge mst_sclk);
            @(negedge clk);
            ser_din = val[i];
        end
    endtask

    task automatic t_reset;
        reg_read(2'd1, v);   check("R3 reset status", v, 8'h00);
        reg_read(2'd0, v);   check("R9 reset control", v, 8'h00);
        check("R4 reset irq", rx_irq, 0);
        check("R10 reset master clock low", mst_sclk, 0);
    endtask

    task automatic t_no_dummy;
        reg_write(2'd0, 8'h03);
        slave_frame(8'hA5);
        reg_read(2'd1, v);   check("R1 frame ignored before dummy read", v, 8'h00);
    endtask

    task automatic t_basic;
        reg_read(2'd2, v);                       // dummy read arms
        slave_frame(8'hA5);
        reg_read(2'd1, v);   check("R3 full after frame", v, 8'h01);
        check("R4 irq with enable", rx_irq, 1);
        reg_read(2'd2, v);   check("R2 data msb first", v, 8'hA5);
        reg_read(2'd1, v);   check("R5 read clears full", v, 8'h00);
        check("R4 irq drops with full", rx_irq, 0);
    endtask

    task automatic t_irq_off;
        reg_write(2'd0, 8'h01);
        slave_frame(8'h3C);
        reg_read(2'd1, v);   check("R3 full irq disabled", v, 8'h01);
        check("R4 no irq when disabled", rx_irq, 0);
        reg_read(2'd2, v);   check("R2 second pattern", v, 8'h3C);
    endtask

    task automatic t_late_read;
        slave_frame(8'h11);
        ext_sel_n = 1'b0; clkn(4);
        slave_bits(8'hF0, 0, 3);
        reg_read(2'd2, v);   check("R6 stale data mid frame", v, 8'h11);
        slave_bits(8'hF0, 4, 7);
        clkn(4); ext_sel_n = 1'b1; clkn(8);
        reg_read(2'd1, v);   check("R6 conflict set full clear", v, 8'h02);
        reg_read(2'd2, v);   check("R6 late frame dropped", v, 8'h11);
    endtask

    task automatic t_err_clear;
        reg_write(2'd1, 8'h02);
        reg_read(2'd1, v);   check("R8 write one keeps flag", v, 8'h02);
        reg_write(2'd1, 8'h00);
        reg_read(2'd1, v);   check("R8 write zero clears flag", v, 8'h00);
    endtask

    task automatic t_late_noread;
        slave_frame(8'h22);
        slave_frame(8'h99);
        reg_read(2'd1, v);   check("R7 full kept no error", v, 8'h01);
        reg_read(2'd2, v);   check("R7 held data kept", v, 8'h22);
    endtask

    task automatic t_abort_en;
        ext_sel_n = 1'b0; clkn(4);
        slave_bits(8'hFF, 0, 3);
        reg_write(2'd0, 8'h00);
        reg_write(2'd0, 8'h01);
        slave_bits(8'hFF, 4, 7);
        clkn(4); ext_sel_n = 1'b1; clkn(8);
        slave_frame(8'h5A);
        reg_read(2'd1, v);   check("R9 disarmed after disable", v, 8'h00);
        reg_read(2'd2, v);                       // re-arm
        slave_frame(8'h5A);
        reg_read(2'd2, v);   check("R9 aligned after abort", v, 8'h5A);
    endtask

    task automatic t_sel_abort;
        ext_sel_n = 1'b0; clkn(4);
        slave_bits(8'hFF, 0, 2);
        clkn(4); ext_sel_n = 1'b1; clkn(8);
        slave_frame(8'hC3);
        reg_read(2'd2, v);   check("R11 select abort realigns", v, 8'hC3);
    endtask

    task automatic t_master;
        reg_write(2'd0, 8'h05);
        edges = 0;
        ser_din = 1'b1;                          // msb of 0x96
        fork master_drive(8'h96); join_none
        reg_read(2'd2, v);
        clkn(120);
        check("R10 eight pulses per read", edges, 8);
        check("R10 clock idle low", mst_sclk, 0);
        reg_read(2'd1, v);   check("R10 full after master frame", v, 8'h01);
        ser_din = 1'b0;                          // msb of 0x4B
        fork master_drive(8'h4B); join_none
        reg_read(2'd2, v);   check("R10 first master data", v, 8'h96);
        clkn(120);
        check("R10 one frame per read", edges, 16);
        reg_write(2'd0, 8'h00);
        reg_read(2'd2, v);   check("R10 second master data", v, 8'h4B);
        clkn(40);
        check("R10 no pulses when disabled", edges, 16);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        clkn(4);
        rst_n = 1'b1;
        clkn(2);
        t_reset();
        t_no_dummy();
        t_basic();
        t_irq_off();
        t_late_read();
        t_err_clear();
        t_late_noread();
        t_abort_en();
        t_sel_abort();
        t_master();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule